// File: doc/BRIEF.md
# Data Register File with Limit Tags

This block holds the data registers of a DSP arithmetic unit. It has sixteen 40-bit registers. Each register is split into three fields: an 8-bit extension in bits 39:32, a 16-bit high half in bits 31:16 and a 16-bit low half in bits 15:0. Each register also carries a one-bit limit tag. The tag tells the store path that the value may need saturating when it leaves over a data bus, because it does not fit in 32 bits.

There are two write ports:
- The ALU result port writes a whole register and recomputes its tag.
- The load port writes any mix of the three fields. In restore mode it instead writes a 9-bit value made of the tag and the extension byte.

There are two independent read ports. Each returns the full register, its tag and the 9-bit save value. Reads always return the state held at the start of the cycle, so new operands can be loaded while the current instruction reads the old ones. The block does not extend load data, saturate stored data or perform arithmetic.

Top module: `dreg_file`

## Requirements
- R1: While rst_ni is low, every register and every tag is cleared to zero.
- R2: An ALU write (alu_we_i) stores all 40 bits of alu_data_i into register alu_addr_i at the clock edge.
- R3: On an ALU write, the tag is set to 1 when bits 39:31 of the written value are not all equal, and cleared to 0 when they are all equal.
- R4: A field load (ld_we_i=1, ld_restore_i=0) writes only the fields selected by ld_mask_i: bit 0 selects the low half (15:0), bit 1 the high half (31:16) and bit 2 the extension (39:32). Each field takes the same bit positions of ld_data_i, and the tag is left unchanged.
- R5: A restore (ld_we_i=1, ld_restore_i=1) writes ld_data_i[7:0] into the extension and ld_data_i[8] into the tag, without recomputing the tag. Bits 31:0 of the register are left unchanged.
- R6: Each read port drives {tag, extension} of the addressed register on its 9-bit save output, with the tag in bit 8.
- R7: When the ALU and load ports target the same register in the same cycle, only the ALU write takes effect. collision_o is 1 in that cycle and 0 otherwise.
- R8: Read outputs show the contents held before the clock edge. A write becomes visible only after that edge, with no bypass.
- R9: The two read ports are independent, so each returns its own addressed register in the same cycle.
- R10: A register that no port writes in a cycle keeps its value and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alu_we_i | input | 1 | ALU write enable |
| alu_addr_i | input | 4 | ALU destination register |
| alu_data_i | input | 40 | ALU result |
| ld_we_i | input | 1 | Load write enable |
| ld_restore_i | input | 1 | 1: 9-bit tag and extension restore; 0: field load |
| ld_mask_i | input | 3 | Field select: bit 2 = extension, bit 1 = high half, bit 0 = low half |
| ld_addr_i | input | 4 | Load destination register |
| ld_data_i | input | 40 | Load data, aligned to register bit positions |
| collision_o | output | 1 | ALU and load target the same register in this cycle |
| rd_a_addr_i | input | 4 | Read port A address |
| rd_a_data_o | output | 40 | Read port A register value |
| rd_a_tag_o | output | 1 | Read port A limit tag |
| rd_a_save_o | output | 9 | Read port A {tag, extension} |
| rd_b_addr_i | input | 4 | Read port B address |
| rd_b_data_o | output | 40 | Read port B register value |
| rd_b_tag_o | output | 1 | Read port B limit tag |
| rd_b_save_o | output | 9 | Read port B {tag, extension} |

## Verification
The bench builds the block with its default parameters: sixteen registers, an 8-bit extension and 16-bit halves. With these defaults, both ends of the address range (registers 0 and 15) can be exercised, and the tag boundary sits at bit 31. Table vectors place values on each side of the 32-bit signed range, so the tag rule is checked both where it sets and where it clears. Directed cases cover:
- partial field loads;
- a restore that forces a tag the rule would not produce;
- a same-register collision;
- reading a register in the same cycle it is written.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
  localparam int unsigned DEF_NUM_REGS = 16;
  localparam int unsigned DEF_EXT_W    = 8;
  localparam int unsigned DEF_HALF_W   = 16;
  // field-select bit positions of the load mask
  localparam int unsigned FLD_LO  = 0;
  localparam int unsigned FLD_HI  = 1;
  localparam int unsigned FLD_EXT = 2;
  localparam int unsigned FLD_NUM = 3;
endpackage

// File: rtl/dreg_tag_calc.sv
module dreg_tag_calc #(
  parameter int unsigned EXT_W  = dreg_pkg::DEF_EXT_W,
  parameter int unsigned HALF_W = dreg_pkg::DEF_HALF_W,
  localparam int unsigned DATA_W = EXT_W + 2 * HALF_W
) (
  input  logic [DATA_W-1:0] value_i,
  output logic              tag_o
);
  // extension plus the fraction sign bit must all agree
  logic [EXT_W:0] top_bits;
  assign top_bits = value_i[DATA_W-1:2*HALF_W-1];
  assign tag_o    = !((&top_bits) || !(|top_bits));
endmodule

// File: rtl/dreg_entry.sv
module dreg_entry #(
  parameter int unsigned EXT_W  = dreg_pkg::DEF_EXT_W,
  parameter int unsigned HALF_W = dreg_pkg::DEF_HALF_W,
  localparam int unsigned DATA_W = EXT_W + 2 * HALF_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        alu_sel_i,
  input  logic [DATA_W-1:0]           alu_data_i,
  input  logic                        alu_tag_i,
  input  logic                        ld_sel_i,
  input  logic                        ld_restore_i,
  input  logic [dreg_pkg::FLD_NUM-1:0] ld_mask_i,
  input  logic [DATA_W-1:0]           ld_data_i,
  output logic [DATA_W-1:0]           q_o,
  output logic                        tag_o
);
  import dreg_pkg::*;
  localparam int unsigned EXT_LSB = 2 * HALF_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      tag_o <= 1'b0;
    end else if (alu_sel_i) begin
      q_o   <= alu_data_i;
      tag_o <= alu_tag_i;
    end else if (ld_sel_i) begin
      if (ld_restore_i) begin
        q_o[DATA_W-1:EXT_LSB] <= ld_data_i[EXT_W-1:0];
        tag_o                 <= ld_data_i[EXT_W];
      end else begin
        if (ld_mask_i[FLD_LO])  q_o[HALF_W-1:0]        <= ld_data_i[HALF_W-1:0];
        if (ld_mask_i[FLD_HI])  q_o[EXT_LSB-1:HALF_W]  <= ld_data_i[EXT_LSB-1:HALF_W];
        if (ld_mask_i[FLD_EXT]) q_o[DATA_W-1:EXT_LSB]  <= ld_data_i[DATA_W-1:EXT_LSB];
      end
    end
  end

  assert_alu_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(alu_sel_i) |-> (q_o == $past(alu_data_i)) && (tag_o == $past(alu_tag_i)));
  assert_alu_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(alu_sel_i && ld_sel_i) |-> (q_o == $past(alu_data_i)));
  assert_load_keeps_tag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ld_sel_i && !alu_sel_i && !ld_restore_i) |-> $stable(tag_o));
  assert_restore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ld_sel_i && !alu_sel_i && ld_restore_i) |->
      (tag_o == $past(ld_data_i[EXT_W])) && $stable(q_o[EXT_LSB-1:0]));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!alu_sel_i && !ld_sel_i) |-> $stable(q_o) && $stable(tag_o));
endmodule

// File: rtl/dreg_read_port.sv
module dreg_read_port #(
  parameter int unsigned NUM_REGS = dreg_pkg::DEF_NUM_REGS,
  parameter int unsigned EXT_W    = dreg_pkg::DEF_EXT_W,
  parameter int unsigned HALF_W   = dreg_pkg::DEF_HALF_W,
  localparam int unsigned DATA_W  = EXT_W + 2 * HALF_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [NUM_REGS-1:0]             tags_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [DATA_W-1:0]               data_o,
  output logic                            tag_o,
  output logic [EXT_W:0]                  save_o
);
  assign data_o = regs_i[addr_i];
  assign tag_o  = tags_i[addr_i];
  assign save_o = {tags_i[addr_i], regs_i[addr_i][DATA_W-1:2*HALF_W]};
endmodule

// File: rtl/dreg_file.sv
module dreg_file #(
  parameter int unsigned NUM_REGS = dreg_pkg::DEF_NUM_REGS,
  parameter int unsigned EXT_W    = dreg_pkg::DEF_EXT_W,
  parameter int unsigned HALF_W   = dreg_pkg::DEF_HALF_W,
  localparam int unsigned DATA_W  = EXT_W + 2 * HALF_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alu_we_i,
  input  logic [ADDR_W-1:0]            alu_addr_i,
  input  logic [DATA_W-1:0]            alu_data_i,
  input  logic                         ld_we_i,
  input  logic                         ld_restore_i,
  input  logic [dreg_pkg::FLD_NUM-1:0] ld_mask_i,
  input  logic [ADDR_W-1:0]            ld_addr_i,
  input  logic [DATA_W-1:0]            ld_data_i,
  output logic                         collision_o,
  input  logic [ADDR_W-1:0]            rd_a_addr_i,
  output logic [DATA_W-1:0]            rd_a_data_o,
  output logic                         rd_a_tag_o,
  output logic [EXT_W:0]               rd_a_save_o,
  input  logic [ADDR_W-1:0]            rd_b_addr_i,
  output logic [DATA_W-1:0]            rd_b_data_o,
  output logic                         rd_b_tag_o,
  output logic [EXT_W:0]               rd_b_save_o
);
  logic                           alu_tag;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0]            tags;

  dreg_tag_calc #(.EXT_W(EXT_W), .HALF_W(HALF_W)) u_tag (
    .value_i(alu_data_i), .tag_o(alu_tag));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic alu_sel, ld_sel;
    assign alu_sel = alu_we_i && (alu_addr_i == ADDR_W'(i));
    assign ld_sel  = ld_we_i  && (ld_addr_i  == ADDR_W'(i));
    dreg_entry #(.EXT_W(EXT_W), .HALF_W(HALF_W)) u_entry (
      .clk_i, .rst_ni,
      .alu_sel_i(alu_sel), .alu_data_i, .alu_tag_i(alu_tag),
      .ld_sel_i(ld_sel), .ld_restore_i, .ld_mask_i, .ld_data_i,
      .q_o(regs[i]), .tag_o(tags[i]));
  end

  assign collision_o = alu_we_i && ld_we_i && (alu_addr_i == ld_addr_i);

  dreg_read_port #(.NUM_REGS(NUM_REGS), .EXT_W(EXT_W), .HALF_W(HALF_W)) u_rd_a (
    .regs_i(regs), .tags_i(tags), .addr_i(rd_a_addr_i),
    .data_o(rd_a_data_o), .tag_o(rd_a_tag_o), .save_o(rd_a_save_o));
  dreg_read_port #(.NUM_REGS(NUM_REGS), .EXT_W(EXT_W), .HALF_W(HALF_W)) u_rd_b (
    .regs_i(regs), .tags_i(tags), .addr_i(rd_b_addr_i),
    .data_o(rd_b_data_o), .tag_o(rd_b_tag_o), .save_o(rd_b_save_o));

  // R7: flag only when both ports are active
  assert_collision_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> alu_we_i && ld_we_i);
  // R6: save value tracks data and tag of the same register
  assert_save_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_save_o == {rd_a_tag_o, rd_a_data_o[DATA_W-1:2*HALF_W]});
endmodule

// File: tb/dreg_file_test.sv
`timescale 1ns/1ps
module dreg_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_we = 0, ld_we = 0, ld_restore = 0;
  logic [3:0]  alu_addr = 0, ld_addr = 0, ra = 0, rb = 0;
  logic [2:0]  ld_mask = 0;
  logic [39:0] alu_data = 0, ld_data = 0;
  logic        coll, ta, tb_;
  logic [39:0] da, db;
  logic [8:0]  sa, sb;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dreg_file uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alu_we_i(alu_we), .alu_addr_i(alu_addr), .alu_data_i(alu_data),
    .ld_we_i(ld_we), .ld_restore_i(ld_restore), .ld_mask_i(ld_mask),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .collision_o(coll),
    .rd_a_addr_i(ra), .rd_a_data_o(da), .rd_a_tag_o(ta), .rd_a_save_o(sa),
    .rd_b_addr_i(rb), .rd_b_data_o(db), .rd_b_tag_o(tb_), .rd_b_save_o(sb));

  // {addr, value, expected tag}
  localparam logic [44:0] VEC [8] = '{
    {4'd0,  40'h00_7FFF_FFFF, 1'b0},
    {4'd1,  40'h00_8000_0000, 1'b1},
    {4'd2,  40'hFF_8000_0000, 1'b0},
    {4'd3,  40'hFF_7FFF_FFFF, 1'b1},
    {4'd4,  40'h01_0000_0000, 1'b1},
    {4'd5,  40'hFF_FFFF_FFFF, 1'b0},
    {4'd9,  40'h7F_0000_1234, 1'b1},
    {4'd15, 40'h00_0000_ABCD, 1'b0}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_we = 0; ld_we = 0; ld_restore = 0; ld_mask = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      ra = 4'(i); #0.1;
      chk("R1 reset data", {24'd0, da}, 64'd0);
      chk("R1 reset tag", {63'd0, ta}, 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R6 R9: vector walk
    for (int v = 0; v < 8; v++) begin
      alu_we = 1; alu_addr = VEC[v][44:41]; alu_data = VEC[v][40:1];
      @(negedge clk); idle();
      ra = VEC[v][44:41]; rb = VEC[v][44:41]; #0.1;
      chk("R2 alu data", {24'd0, da}, {24'd0, VEC[v][40:1]});
      chk("R3 tag", {63'd0, ta}, {63'd0, VEC[v][0]});
      chk("R6 save", {55'd0, sb}, {55'd0, VEC[v][0], VEC[v][40:33]});
      chk("R9 port b data", {24'd0, db}, {24'd0, VEC[v][40:1]});
    end
    ra = 4'd1; rb = 4'd2; #0.1;
    chk("R9 port a", {24'd0, da}, {24'd0, 40'h00_8000_0000});
    chk("R9 port b", {24'd0, db}, {24'd0, 40'hFF_8000_0000});

    // R4: load low half only into reg 1 (tag stays 1)
    ld_we = 1; ld_addr = 4'd1; ld_mask = 3'b001; ld_data = 40'hAA_BBBB_CCCC;
    @(negedge clk); idle(); ra = 4'd1; #0.1;
    chk("R4 low only", {24'd0, da}, {24'd0, 40'h00_8000_CCCC});
    chk("R4 tag kept", {63'd0, ta}, 64'd1);
    // R4: ext+high into reg 1
    ld_we = 1; ld_addr = 4'd1; ld_mask = 3'b110; ld_data = 40'h12_3456_0000;
    @(negedge clk); idle(); #0.1;
    chk("R4 ext+hi", {24'd0, da}, {24'd0, 40'h12_3456_CCCC});
    chk("R4 tag kept2", {63'd0, ta}, 64'd1);

    // R5: restore reg 0 with tag 1, ext 0x00 (rule would give 0)
    ld_we = 1; ld_restore = 1; ld_addr = 4'd0; ld_mask = 3'b000; ld_data = 40'h00_FFFF_F100;
    @(negedge clk); idle(); ra = 4'd0; #0.1;
    chk("R5 restore tag", {63'd0, ta}, 64'd1);
    chk("R5 restore data", {24'd0, da}, {24'd0, 40'h00_7FFF_FFFF});
    ld_we = 1; ld_restore = 1; ld_addr = 4'd0; ld_data = 40'h0_5A;
    @(negedge clk); idle(); #0.1;
    chk("R5 restore ext", {55'd0, sa}, {55'd0, 9'h05A});

    // R7: collision on reg 3
    alu_we = 1; alu_addr = 4'd3; alu_data = 40'h00_0000_0042;
    ld_we = 1; ld_addr = 4'd3; ld_mask = 3'b111; ld_data = 40'hFF_FFFF_FFFF; #0.1;
    chk("R7 collision flag", {63'd0, coll}, 64'd1);
    @(negedge clk); idle(); ra = 4'd3; #0.1;
    chk("R7 alu wins", {24'd0, da}, {24'd0, 40'h00_0000_0042});
    chk("R7 tag from alu", {63'd0, ta}, 64'd0);
    chk("R7 flag cleared", {63'd0, coll}, 64'd0);
    alu_we = 1; alu_addr = 4'd4; ld_we = 1; ld_addr = 4'd5; ld_mask = 0; #0.1;
    chk("R7 no flag diff addr", {63'd0, coll}, 64'd0);
    @(negedge clk); idle();

    // R8: same-cycle read shows old value
    ra = 4'd15;
    alu_we = 1; alu_addr = 4'd15; alu_data = 40'h80_0000_0000; #0.1;
    chk("R8 old value", {24'd0, da}, {24'd0, 40'h00_0000_ABCD});
    @(negedge clk); idle(); #0.1;
    chk("R8 new value", {24'd0, da}, {24'd0, 40'h80_0000_0000});
    chk("R3 tag neg ext", {63'd0, ta}, 64'd1);

    // R10: reg 9 untouched by all later writes
    ra = 4'd9; #0.1;
    chk("R10 hold", {24'd0, da}, {24'd0, 40'h7F_0000_1234});
    chk("R10 tag hold", {63'd0, ta}, 64'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule